// File: doc/BRIEF.md
# Chip-Enable Strobed Byte Memory Controller

This block sits on the host side of a byte-wide nonvolatile memory. That memory latches its address on every falling edge of an active-low chip enable. It also needs chip enable held high for a precharge interval between accesses. The host side is a single request channel with valid/ready handshaking: a write flag, an address and write data. Read results come back on a response channel that has a one-cycle valid pulse and carries no backpressure.

Each accepted request runs one complete bus cycle. First comes a setup cycle, in which the address and write strobe are presented and chip enable is still high. Then chip enable is held low for a fixed number of clock cycles. Then chip enable returns high for the precharge count. Chip enable is never held low across two accesses, and the low time can never exceed a configured maximum.

Writes are controlled by chip enable. Write enable is already low when chip enable falls, and output enable stays high. Reads assert output enable at the same time as the chip-enable fall. The read data is captured on the clock edge that ends the low phase. All timing is expressed in clock cycles through parameters. At 250 MHz, the defaults of 30 low cycles and 15 precharge cycles give a low time of 120 ns and a high time of at least 60 ns.

Top module: `strobe_mem_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1.
- R2: Each accepted request produces exactly one fall of mem_ce_n followed by one rise. mem_ce_n stays low for exactly LOW_CYC clock cycles (default 30).
- R3: mem_ce_n is never low for more than MAX_LOW_CYC consecutive cycles (default 500), and parameters with LOW_CYC > MAX_LOW_CYC are rejected.
- R4: mem_ce_n stays high for at least PC_CYC cycles (default 15) before each fall. req_ready is 0 from the acceptance edge until the precharge ends. With a waiting request, the next request is accepted exactly LOW_CYC + PC_CYC + 2 cycles after the previous one.
- R5: mem_addr carries the request's address one cycle before the chip-enable fall and holds it unchanged while mem_ce_n is low.
- R6: For a write (req_write = 1), mem_we_n goes low one cycle before the chip-enable fall and rises with mem_ce_n. mem_oe_n stays 1 throughout. mem_dq_oe is 1 and mem_dq_out equals the write data for the whole low phase, and mem_dq_oe drops when chip enable rises.
- R7: For a read (req_write = 0), mem_dq_oe is 0 for at least one cycle before mem_oe_n falls, and mem_oe_n falls together with mem_ce_n. mem_dq_in is captured on the edge that ends the low phase. rsp_valid is a one-cycle pulse in the first cycle that mem_ce_n is high again, with rsp_rdata holding the captured byte.
- R8: A write produces no rsp_valid pulse. The number of responses equals the number of accepted reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | DATA_W (8) | Read data |
| mem_addr | output | ADDR_W (13) | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Host drives the data bus when 1 |
| mem_dq_in | input | DATA_W (8) | Data returned by the memory |

## Verification
A wrong phase counter shows up at the very next chip-enable edge: the low time is not exactly LOW_CYC, the high gap before the next fall is short, or ready returns early. All of these are visible within one access of roughly 47 cycles. A wrong latched direction flag shows up at the chip-enable fall. It appears as output enable asserted during a write, write enable left high, or a spurious or missing response pulse at the following rise. A capture on the wrong edge returns a placeholder byte instead of the stored one, and the response scoreboard reports it on that access.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_PRE   = 2'd3
  } cec_state_t;
endpackage

// File: rtl/cec_timer.sv
module cec_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cec_seq.sv
module cec_seq
  import cec_pkg::*;
#(
  parameter int LOW_CYC = 30,
  parameter int PC_CYC  = 15,
  parameter int CW      = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic start_low,
  output logic end_low
);
  localparam logic [CW-1:0] LOW_LOAD = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] PC_LOAD  = CW'(PC_CYC - 1);

  cec_state_t state, state_nx;
  logic       t_zero;
  logic       t_load;
  logic [CW-1:0] t_val;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign start_low = (state == ST_SETUP);
  assign end_low   = (state == ST_LOW) && t_zero;

  assign t_load = start_low || end_low;
  assign t_val  = start_low ? LOW_LOAD : PC_LOAD;

  cec_timer #(.W(CW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req_valid) state_nx = ST_SETUP;
      ST_SETUP: state_nx = ST_LOW;
      ST_LOW:   if (t_zero) state_nx = ST_PRE;
      ST_PRE:   if (t_zero) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  AST_PRE_EXIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_PRE && state == ST_IDLE) |-> $past(t_zero)) else $error("precharge left early"); // R4
endmodule

// File: rtl/cec_bus.sv
module cec_bus #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int LOW_CYC     = 30,
  parameter int MAX_LOW_CYC = 500,
  parameter int PC_CYC      = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              start_low,
  input  logic              end_low,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_n_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic [DATA_W-1:0] dq_out_q,
  output logic              dq_oe_q,
  output logic              rsp_valid_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      ce_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_out_q    <= '0;
      dq_oe_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
      wr_q        <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        addr_q   <= req_addr;
        wr_q     <= req_write;
        we_n_q   <= ~req_write;
        dq_out_q <= req_wdata;
        dq_oe_q  <= req_write;
      end
      if (start_low) begin
        ce_n_q <= 1'b0;
        oe_n_q <= wr_q;
      end
      if (end_low) begin
        ce_n_q  <= 1'b1;
        we_n_q  <= 1'b1;
        oe_n_q  <= 1'b1;
        dq_oe_q <= 1'b0;
        if (!wr_q) begin
          rsp_valid_q <= 1'b1;
          rdata_q     <= mem_dq_in;
        end
      end
    end
  end

  // Independent phase-length monitors for the checks below
  localparam int MW = $clog2(MAX_LOW_CYC + PC_CYC + 2);
  localparam logic [MW-1:0] LOW_V  = MW'(LOW_CYC);
  localparam logic [MW-1:0] MAXL_V = MW'(MAX_LOW_CYC);
  localparam logic [MW-1:0] PC_V   = MW'(PC_CYC);
  localparam logic [MW-1:0] PCM1_V = MW'(PC_CYC - 1);
  logic [MW-1:0] lo_mon, hi_mon;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_mon <= '0;
      hi_mon <= PC_V;
    end else if (ce_n_q) begin
      lo_mon <= '0;
      if (hi_mon < PC_V) hi_mon <= hi_mon + 1'b1;
    end else begin
      hi_mon <= '0;
      if (lo_mon <= MAXL_V) lo_mon <= lo_mon + 1'b1;
    end
  end

  AST_CE_LOW_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(ce_n_q) |-> (lo_mon == LOW_V)) else $error("low phase length"); // R2
  AST_CE_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
    lo_mon <= MAXL_V) else $error("low phase too long"); // R3
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n_q) |-> ($past(hi_mon) >= PCM1_V)) else $error("precharge short"); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q)) else $error("address moved"); // R5
  AST_WE_LEAD: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce_n_q) && !we_n_q) |-> $past(!we_n_q)) else $error("write strobe late"); // R6
  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (rst)
    !we_n_q |-> oe_n_q) else $error("output enable in write"); // R6
  AST_OE_TURN: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n_q) |-> ($past(!dq_oe_q) && !dq_oe_q)) else $error("bus contention"); // R7
  AST_RSP_EDGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> $rose(ce_n_q)) else $error("response misplaced"); // R7
endmodule

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int LOW_CYC     = 30,
  parameter int MAX_LOW_CYC = 500,
  parameter int PC_CYC      = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int CNT_MAX = (MAX_LOW_CYC > PC_CYC) ? MAX_LOW_CYC : PC_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  initial begin
    AST_PARAM_RANGE: assert (LOW_CYC >= 1 && PC_CYC >= 1 && LOW_CYC <= MAX_LOW_CYC)
      else $error("timing parameters out of range"); // R3
  end

  logic accept, start_low, end_low;

  cec_seq #(
    .LOW_CYC (LOW_CYC),
    .PC_CYC  (PC_CYC),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .start_low (start_low),
    .end_low   (end_low)
  );

  cec_bus #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .LOW_CYC     (LOW_CYC),
    .MAX_LOW_CYC (MAX_LOW_CYC),
    .PC_CYC      (PC_CYC)
  ) u_bus (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .start_low   (start_low),
    .end_low     (end_low),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_dq_in   (mem_dq_in),
    .addr_q      (mem_addr),
    .ce_n_q      (mem_ce_n),
    .we_n_q      (mem_we_n),
    .oe_n_q      (mem_oe_n),
    .dq_out_q    (mem_dq_out),
    .dq_oe_q     (mem_dq_oe),
    .rsp_valid_q (rsp_valid),
    .rdata_q     (rsp_rdata)
  );

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready) else $error("ready during access"); // R4
endmodule

// File: tb/sim_strobe_mem_ctrl.sv
module sim_strobe_mem_ctrl;
  localparam int AW = 13, DW = 8, LOWC = 30, MAXC = 500, PCC = 15;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } acc_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  strobe_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LOW_CYC(LOWC), .MAX_LOW_CYC(MAXC), .PC_CYC(PCC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int total = 0, bad = 0;
  int n_reads = 0, n_sent = 0, n_rsp = 0, n_falls = 0;
  logic [DW-1:0] dev_mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  acc_t acc_q[$];
  logic [DW-1:0] exp_q[$];

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) ^ DW'(a >> 5) ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Memory model: data valid only in the last low cycle of a read
  int devcnt = 0;
  always @(posedge clk) begin
    if (mem_ce_n) devcnt <= 0;
    else begin
      devcnt <= devcnt + 1;
      if (!mem_we_n && devcnt == LOWC - 1) dev_mem[mem_addr] <= mem_dq_out;
    end
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && devcnt >= LOWC - 1) ? dev_mem[mem_addr] : 8'hEE;

  // Bus monitor and response scoreboard
  logic p_ce_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
  int lo_len = 0, hi_len = 1000;
  bit run_ok = 1'b1;
  acc_t cur = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_ce_n && !mem_ce_n) begin
        n_falls++;
        chk(hi_len >= PCC, "R4 precharge gap", hi_len, PCC);
        if (acc_q.size() == 0) chk(1'b0, "R2 unexpected access", 0, 1);
        else cur = acc_q.pop_front();
        chk(mem_addr == cur.a, "R5 address at fall", int'(mem_addr), int'(cur.a));
        if (cur.wr)
          chk(!mem_we_n && !p_we_n && mem_oe_n, "R6 write strobe lead", int'({p_we_n, mem_we_n, mem_oe_n}), 1);
        else
          chk(!mem_oe_n && !p_dq_oe && mem_we_n, "R7 read turnaround", int'({p_dq_oe, mem_oe_n, mem_we_n}), 1);
        lo_len = 1;
        run_ok = 1'b1;
      end else if (!mem_ce_n) lo_len++;
      if (!mem_ce_n) begin
        if (mem_addr != cur.a) run_ok = 1'b0;
        if (cur.wr && (!mem_dq_oe || mem_dq_out != cur.d || mem_we_n || !mem_oe_n)) run_ok = 1'b0;
      end
      if (!p_ce_n && mem_ce_n) begin
        chk(lo_len == LOWC, "R2 low length", lo_len, LOWC);
        chk(lo_len <= MAXC, "R3 low maximum", lo_len, MAXC);
        chk(run_ok, "R5 R6 stable during low", 0, 1);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R6 release at rise", int'({mem_we_n, mem_oe_n, mem_dq_oe}), 6);
        hi_len = 1;
      end else if (mem_ce_n) hi_len++;
      if (rsp_valid) begin
        n_rsp++;
        chk(!p_ce_n && mem_ce_n, "R7 response timing", int'({p_ce_n, mem_ce_n}), 1);
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", int'(rsp_rdata), -1);
        else begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          chk(rsp_rdata == e, "R7 read data", int'(rsp_rdata), int'(e));
        end
      end
    end
    p_ce_n  = mem_ce_n;
    p_we_n  = mem_we_n;
    p_dq_oe = mem_dq_oe;
  end

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input bit wr, input int a, input int d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = DW'(d);
    while (!req_ready) @(negedge clk);
    acc_q.push_back({wr, AW'(a), DW'(d)});
    n_sent++;
    if (wr) exp_mem[a] = DW'(d);
    else begin
      exp_q.push_back(exp_mem[a]);
      n_reads++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dev_mem[i] = pat(i);
      exp_mem[i] = pat(i);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle high", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 bus released and ready", int'({mem_dq_oe, rsp_valid, req_ready}), 1);

    // Boundary addresses, then read back plus an unwritten location
    send(1'b1, 0, 8'h5A);
    send(1'b1, DEPTH - 1, 8'hC3);
    send(1'b0, 0, 0);
    send(1'b0, DEPTH - 1, 0);
    send(1'b0, 12'hABC, 0);

    // R4: acceptance-to-ready spacing
    begin
      int k = 1;
      send(1'b1, 4, 8'h11);
      chk(!req_ready, "R4 ready low after accept", int'(req_ready), 0);
      while (!req_ready) begin
        @(negedge clk);
        k++;
      end
      chk(k == LOWC + PCC + 2, "R4 ready return cycle", k, LOWC + PCC + 2);
    end

    // Back-to-back mixed traffic, same row and far addresses
    for (int i = 0; i < 16; i++) begin
      automatic int a = (i / 2) * 517 % DEPTH;
      if (i % 2 == 0) send(1'b1, a, i * 11 + 1);
      else            send(1'b0, a, 0);
    end
    send(1'b0, 5, 0);
    send(1'b0, 4, 0);

    repeat (100) @(negedge clk);
    // R8: writes give no response; R2: one fall per request
    chk(n_rsp == n_reads, "R8 response count", n_rsp, n_reads);
    chk(exp_q.size() == 0, "R8 pending responses", exp_q.size(), 0);
    chk(n_falls == n_sent, "R2 one fall per request", n_falls, n_sent);
    finish_run();
  end
endmodule